// File: doc/BRIEF.md
# PIO Activity Latch and Event Qualifier

This block watches a bank of general-purpose input channels and decides whether the device should answer a conditional search. Each channel's pin level is brought into the clock domain through a synchronizer. A change in either direction on a channel sets that channel's sticky activity flag. The flag stays set until the next power-on reset or until a latch-clear command arrives.

Three configuration registers decide the outcome: a channel mask, a polarity byte and a control/status byte. The control byte picks the condition source, either the live pin levels or the activity flags. It also picks the combining term, either any selected channel or all of them. A sticky power-on flag in the same byte forces the result true until software writes it to zero. The result is a single registered flag. Bit-level signalling, search arbitration and the reset/strobe pin driver are handled by neighbouring logic.

Top module: `pio_event_qual`

## Requirements
- R1: A synchronous reset (`rst` high) has these effects. Activity flags, mask, polarity and synchronized pin state all go to zero. The control byte reads 08h with `vcc_present` low, because the power-on flag is set. `cond_met` reads 1.
- R2: `pin_state` bit n reflects `pin_in` bit n, with channel 7 in bit 7 and channel 0 in bit 0. The value appears two clock edges after the input changes.
- R3: A rising or a falling change on a channel sets that channel's bit of `latch_state` on the third clock edge after the input changes. The bit stays set after the pin returns to its old level.
- R4: A one-cycle `latch_clr` pulse clears all activity flags on the clock edge that samples it.
- R5: If a new change reaches a channel's flag on the same edge as `latch_clr`, that channel's flag is left set, while the other channels are cleared.
- R6: `ctl_rd` has this layout: bit 7 is `vcc_present`, bits 6..4 read 0, bit 3 is the power-on flag, bit 2 is a stored spare bit, bit 1 is the term select and bit 0 is the source select. A write takes effect on the next edge, and written values in bits 6..4 are ignored.
- R7: Writing 0 to bit 3 of the control byte clears the power-on flag. Writing 1 to it never sets the flag. While the flag is set, `cond_met` is 1 whatever the channel condition.
- R8: Source select 0 uses the synchronized pin levels as the condition source. Source select 1 uses the activity flags.
- R9: Term select 0 makes the result true if any selected channel is active (OR). Term select 1 requires every selected channel to be active (AND).
- R10: A channel takes part only when its `mask_rd` bit is 1. It counts as active when its source bit equals its `pol_rd` bit. With the mask all zero and the power-on flag clear, `cond_met` is 0 in both terms. Mask and polarity writes read back on the next edge.
- R11: `cond_met` is registered. It follows a change in its inputs (register value, pin state or flag) one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| pin_in | input | 8 | Asynchronous channel input levels |
| vcc_present | input | 1 | Supply-present status shown in control bit 7 |
| latch_clr | input | 1 | Clear all activity flags |
| mask_we | input | 1 | Write strobe for the channel mask |
| mask_wdata | input | 8 | Channel mask write data |
| pol_we | input | 1 | Write strobe for the polarity byte |
| pol_wdata | input | 8 | Polarity write data |
| ctl_we | input | 1 | Write strobe for the control byte |
| ctl_wdata | input | 8 | Control byte write data |
| pin_state | output | 8 | Synchronized pin levels |
| latch_state | output | 8 | Activity flags |
| mask_rd | output | 8 | Channel mask readback |
| pol_rd | output | 8 | Polarity readback |
| ctl_rd | output | 8 | Control/status readback |
| cond_met | output | 1 | Conditional-search qualification flag |

## Verification
An input change shows up on `pin_state` after two edges and on `latch_state` after three. It reaches `cond_met` after three edges through the pin source and after four through the flag source. A register write reads back after one edge and affects `cond_met` after two. The bench drives every stimulus on the falling clock edge and counts exactly that many rising edges before it samples, 1 ns after the edge. It also samples one edge early where that shows an output has not yet moved. The clear-with-change case is lined up so that the clear pulse covers the third edge after the pin change.

// File: rtl/pio_evq_pkg.sv
`timescale 1ns/1ps
package pio_evq_pkg;

    typedef enum logic { SRC_PIN = 1'b0, SRC_LATCH = 1'b1 } src_e;
    typedef enum logic { TERM_OR = 1'b0, TERM_AND = 1'b1 } term_e;

    // Field order matches control byte bits 3..0
    typedef struct packed {
        logic  porl;
        logic  spare;
        term_e term;
        src_e  src;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{porl: 1'b1, spare: 1'b0, term: TERM_OR, src: SRC_PIN};

    function automatic ctl_t ctl_update(ctl_t cur, logic [3:0] wd);
        ctl_t nxt;
        nxt.porl  = cur.porl & wd[3];
        nxt.spare = wd[2];
        nxt.term  = term_e'(wd[1]);
        nxt.src   = src_e'(wd[0]);
        return nxt;
    endfunction

    function automatic logic [7:0] ctl_pack(logic vcc, ctl_t c);
        return {vcc, 3'b000, c};
    endfunction

endpackage

// File: rtl/pio_sync_edge.sv
`timescale 1ns/1ps
module pio_sync_edge #(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_async,
    input  logic         latch_clr,
    output logic [W-1:0] pin_sync,
    output logic [W-1:0] latch_q
);
    localparam int FILL_MAX = SYNC_STAGES + 1;
    localparam int FILL_W   = $clog2(FILL_MAX + 1);

    for (genvar c = 0; c < W; c++) begin : g_ch
        logic [SYNC_STAGES-1:0] stg;
        always_ff @(posedge clk) begin
            if (rst) stg <= '0;
            else     stg <= {stg[SYNC_STAGES-2:0], pin_async[c]};
        end
        assign pin_sync[c] = stg[SYNC_STAGES-1];
    end

    logic [W-1:0]      prev_q;
    logic [FILL_W-1:0] fill_q;
    logic              armed;
    logic [W-1:0]      edge_hit;

    // Edges are only trusted once the pipeline holds real samples
    assign armed    = (fill_q == FILL_W'(FILL_MAX));
    assign edge_hit = armed ? (pin_sync ^ prev_q) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            fill_q  <= '0;
            latch_q <= '0;
        end else begin
            prev_q  <= pin_sync;
            if (!armed) fill_q <= fill_q + FILL_W'(1);
            latch_q <= (latch_q & ~{W{latch_clr}}) | edge_hit;
        end
    end

    // R3
    latch_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !latch_clr |=> ((latch_q & $past(latch_q)) == $past(latch_q)));
    // R4
    latch_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (latch_clr && edge_hit == '0) |=> (latch_q == '0));
    // R5
    clr_keeps_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (latch_clr && edge_hit != '0) |=> ((latch_q & $past(edge_hit)) == $past(edge_hit)));

endmodule

// File: rtl/pio_cfg_regs.sv
`timescale 1ns/1ps
module pio_cfg_regs
    import pio_evq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         vcc_present,
    input  logic         mask_we,
    input  logic [W-1:0] mask_wdata,
    input  logic         pol_we,
    input  logic [W-1:0] pol_wdata,
    input  logic         ctl_we,
    input  logic [7:0]   ctl_wdata,
    output logic [W-1:0] mask_q,
    output logic [W-1:0] pol_q,
    output ctl_t         ctl_q,
    output logic [7:0]   ctl_rd
);
    logic unused_hi_bits;
    assign unused_hi_bits = ^ctl_wdata[7:4];

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            pol_q  <= '0;
            ctl_q  <= CTL_RESET;
        end else begin
            if (mask_we) mask_q <= mask_wdata;
            if (pol_we)  pol_q  <= pol_wdata;
            if (ctl_we)  ctl_q  <= ctl_update(ctl_q, ctl_wdata[3:0]);
        end
    end

    assign ctl_rd = ctl_pack(vcc_present, ctl_q);

    // R7
    porl_no_set_chk: assert property (@(posedge clk) disable iff (rst)
        !$rose(ctl_q.porl));
    // R6
    spare_write_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_we |=> (ctl_rd[2] == $past(ctl_wdata[2])));

endmodule

// File: rtl/pio_match.sv
`timescale 1ns/1ps
module pio_match
    import pio_evq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_sync,
    input  logic [W-1:0] latch_q,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] pol,
    input  logic         porl,
    input  term_e        term,
    input  src_e         src,
    output logic         cond_met
);
    logic [W-1:0] source;
    logic [W-1:0] hit;
    logic         any_hit;
    logic         all_hit;
    logic         chan_ok;

    assign source  = (src == SRC_LATCH) ? latch_q : pin_sync;
    assign hit     = mask & ~(source ^ pol);
    assign any_hit = |hit;
    assign all_hit = (mask != '0) && (hit == mask);
    assign chan_ok = (term == TERM_AND) ? all_hit : any_hit;

    always_ff @(posedge clk) begin
        if (rst) cond_met <= 1'b1;
        else     cond_met <= porl | chan_ok;
    end

    // R7
    porl_forces_chk: assert property (@(posedge clk) disable iff (rst)
        porl |=> cond_met);
    // R10
    empty_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (mask == '0 && !porl) |=> !cond_met);

endmodule

// File: rtl/pio_event_qual.sv
`timescale 1ns/1ps
module pio_event_qual
    import pio_evq_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_in,
    input  logic         vcc_present,
    input  logic         latch_clr,
    input  logic         mask_we,
    input  logic [W-1:0] mask_wdata,
    input  logic         pol_we,
    input  logic [W-1:0] pol_wdata,
    input  logic         ctl_we,
    input  logic [7:0]   ctl_wdata,
    output logic [W-1:0] pin_state,
    output logic [W-1:0] latch_state,
    output logic [W-1:0] mask_rd,
    output logic [W-1:0] pol_rd,
    output logic [7:0]   ctl_rd,
    output logic         cond_met
);
    ctl_t ctl_q;

    pio_sync_edge #(.W(W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .pin_async (pin_in),
        .latch_clr (latch_clr),
        .pin_sync  (pin_state),
        .latch_q   (latch_state)
    );

    pio_cfg_regs #(.W(W)) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .vcc_present (vcc_present),
        .mask_we     (mask_we),
        .mask_wdata  (mask_wdata),
        .pol_we      (pol_we),
        .pol_wdata   (pol_wdata),
        .ctl_we      (ctl_we),
        .ctl_wdata   (ctl_wdata),
        .mask_q      (mask_rd),
        .pol_q       (pol_rd),
        .ctl_q       (ctl_q),
        .ctl_rd      (ctl_rd)
    );

    pio_match #(.W(W)) u_match (
        .clk      (clk),
        .rst      (rst),
        .pin_sync (pin_state),
        .latch_q  (latch_state),
        .mask     (mask_rd),
        .pol      (pol_rd),
        .porl     (ctl_q.porl),
        .term     (ctl_q.term),
        .src      (ctl_q.src),
        .cond_met (cond_met)
    );

endmodule

// File: tb/pio_event_qual_test.sv
`timescale 1ns/1ps
module pio_event_qual_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pin_in = '0;
    logic       vcc_present = 1'b0;
    logic       latch_clr = 1'b0;
    logic       mask_we = 1'b0, pol_we = 1'b0, ctl_we = 1'b0;
    logic [7:0] mask_wdata = '0, pol_wdata = '0, ctl_wdata = '0;
    logic [7:0] pin_state, latch_state, mask_rd, pol_rd, ctl_rd;
    logic       cond_met;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    pio_event_qual uut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .vcc_present(vcc_present),
        .latch_clr(latch_clr), .mask_we(mask_we), .mask_wdata(mask_wdata),
        .pol_we(pol_we), .pol_wdata(pol_wdata), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .pin_state(pin_state), .latch_state(latch_state), .mask_rd(mask_rd),
        .pol_rd(pol_rd), .ctl_rd(ctl_rd), .cond_met(cond_met)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_pins(logic [7:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        latch_clr = 1'b1;
        @(negedge clk);
        latch_clr = 1'b0;
    endtask

    // which: 0 mask, 1 polarity, 2 control
    task automatic wr(int which, logic [7:0] d);
        @(negedge clk);
        mask_we = (which == 0); pol_we = (which == 1); ctl_we = (which == 2);
        mask_wdata = d; pol_wdata = d; ctl_wdata = d;
        @(negedge clk);
        mask_we = 0; pol_we = 0; ctl_we = 0;
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        step(1);
        chk("R1 latch", latch_state, 8'h00);
        chk("R1 mask", mask_rd, 8'h00);
        chk("R1 pol", pol_rd, 8'h00);
        chk("R1 ctl", ctl_rd, 8'h08);
        chk("R1 cond", {7'd0, cond_met}, 8'h01);
        chk("R1 pins", pin_state, 8'h00);
        @(negedge clk);
        vcc_present = 1'b1;
        #1 chk("R6 vcc bit", ctl_rd, 8'h88);
        vcc_present = 1'b0;
        step(3);
    endtask

    task automatic t_pin_mirror();
        set_pins(8'hA5);
        step(1);
        chk("R2 not yet", pin_state, 8'h00);
        step(1);
        chk("R2 mirror", pin_state, 8'hA5);
        chk("R3 before edge3", latch_state, 8'h00);
        step(1);
        chk("R3 rise", latch_state, 8'hA5);
    endtask

    task automatic t_latch_clear();
        pulse_clr();
        chk("R4 clear", latch_state, 8'h00);
    endtask

    task automatic t_fall_edge();
        set_pins(8'h00);
        step(3);
        chk("R3 fall", latch_state, 8'hA5);
        step(2);
        chk("R3 sticky", latch_state, 8'hA5);
    endtask

    task automatic t_clear_edge();
        set_pins(8'h02);
        step(2);
        @(negedge clk);
        latch_clr = 1'b1;
        step(1);
        chk("R5 clr+edge", latch_state, 8'h02);
        @(negedge clk);
        latch_clr = 1'b0;
        step(2);
        chk("R5 held", latch_state, 8'h02);
    endtask

    task automatic t_porl();
        wr(2, 8'h08);
        chk("R7 keep", ctl_rd, 8'h08);
        step(1);
        chk("R7 forced", {7'd0, cond_met}, 8'h01);
        wr(2, 8'h00);
        chk("R7 cleared", ctl_rd, 8'h00);
        step(1);
        chk("R7 cond drop", {7'd0, cond_met}, 8'h00);
        wr(2, 8'h08);
        chk("R7 no set", ctl_rd, 8'h00);
    endtask

    task automatic t_ctl_layout();
        vcc_present = 1'b1;
        wr(2, 8'hF7);
        chk("R6 layout", ctl_rd, 8'h87);
        vcc_present = 1'b0;
        wr(2, 8'h00);
        chk("R6 zero", ctl_rd, 8'h00);
    endtask

    task automatic t_empty_mask();
        wr(1, 8'hFF);
        wr(2, 8'h02);
        step(1);
        chk("R10 empty AND", {7'd0, cond_met}, 8'h00);
        wr(2, 8'h00);
        step(1);
        chk("R10 empty OR", {7'd0, cond_met}, 8'h00);
    endtask

    task automatic t_combine();
        wr(0, 8'h03);
        wr(1, 8'h03);
        chk("R10 mask rd", mask_rd, 8'h03);
        chk("R10 pol rd", pol_rd, 8'h03);
        step(1);
        chk("R9 OR one", {7'd0, cond_met}, 8'h01);
        wr(2, 8'h02);
        step(1);
        chk("R9 AND one", {7'd0, cond_met}, 8'h00);
        set_pins(8'h03);
        step(2);
        chk("R11 not yet", {7'd0, cond_met}, 8'h00);
        step(1);
        chk("R9 AND all", {7'd0, cond_met}, 8'h01);
    endtask

    task automatic t_polarity();
        wr(1, 8'h00);
        step(1);
        chk("R10 pol low", {7'd0, cond_met}, 8'h00);
        set_pins(8'h00);
        step(3);
        chk("R10 active low", {7'd0, cond_met}, 8'h01);
    endtask

    task automatic t_source();
        pulse_clr();
        chk("R4 clear2", latch_state, 8'h00);
        wr(0, 8'h04);
        wr(1, 8'h04);
        wr(2, 8'h01);
        step(1);
        chk("R8 latch src idle", {7'd0, cond_met}, 8'h00);
        set_pins(8'h04);
        step(1);
        set_pins(8'h00);
        step(3);
        chk("R8 latch flag", latch_state, 8'h04);
        chk("R8 latch src", {7'd0, cond_met}, 8'h01);
        wr(2, 8'h00);
        step(1);
        chk("R8 pin src", {7'd0, cond_met}, 8'h00);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_pin_mirror();
        t_latch_clear();
        t_fall_edge();
        t_clear_edge();
        t_porl();
        t_ctl_layout();
        t_empty_mask();
        t_combine();
        t_polarity();
        t_source();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule